// File: doc/BRIEF.md
# Integer ALU with condition codes

This block is the integer execute stage of a 32-bit processor core. Each cycle that an operation is presented it combines two operands under one of sixteen operation codes and registers the result, a write-back enable, a condition-flag update and a trap request. The block owns the integer condition flags (negative, zero, overflow, carry). The carry-in and borrow-in forms read the stored carry flag, so a chain of dependent add-with-carry or subtract-with-borrow operations can issue back to back.

The operations cover bitwise logic, including forms that complement the second operand, add and subtract with or without carry or borrow in, tagged add and subtract for runtimes that keep type tags in the two low bits of a word, the three shifts, and the load-upper-immediate operation. Flag updates are chosen per operation by `set_cc`. A tagged operation issued with `trap_form` set becomes a checked operation: on overflow it raises a trap instead of writing anything.

Top module: `int_exec_alu`

## Requirements
- R1: Operation codes 0 to 5 give a&b, a|b, a^b, a&~b, a|~b and a^~b respectively. The result appears on `result` with `res_we` high one cycle after the issue edge.
- R2: When flags are updated, N is bit 31 of the result and Z is 1 exactly when the result is zero. `cc_flags` carries {N,Z,V,C} in bits 3 down to 0.
- R3: Flag-updating logic operations (codes 0 to 5), shifts (12 to 14) and set-high (15) clear V and C.
- R4: Add (code 6) sets C to the carry out of bit 31 and sets V when both operands share a sign that the result lacks.
- R5: Subtract (code 8) computes a-b and sets C to the borrow out. V is set when the operand signs differ and the result sign differs from a.
- R6: Add-with-carry (code 7) and subtract-with-borrow (code 9) take the stored C flag as carry or borrow in. Codes 6 and 8 use 0 regardless of C.
- R7: Tagged add (code 10) and tagged subtract (code 11) behave as add and subtract, except that V is also set when bits [1:0] of either operand are nonzero.
- R8: A tagged operation with `trap_form` high and V=1 raises `trap_req` with `trap_code` 0x0A and suppresses write-back and the flag update. Without overflow it writes back and updates the flags even when `set_cc` is low. `trap_form` has no effect on other codes.
- R9: Codes 12, 13 and 14 shift a left logically, right logically and right arithmetically by the amount held in b[4:0]. Higher bits of b are ignored.
- R10: Set-high (code 15) places `imm22` at result bits [31:10] and clears bits [9:0].
- R11: The stored flags appear in `status_word` at bit 23 (N), 22 (Z), 21 (V) and 20 (C), with all other bits zero. They change only in a cycle with `cc_we` high; `set_cc` low or `in_valid` low leaves them unchanged.
- R12: During and after reset, and with no valid issue, `res_we`, `cc_we` and `trap_req` are low. After reset the flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 4 | Operation code (see requirements) |
| set_cc | input | 1 | Operation updates the flags |
| trap_form | input | 1 | Tagged operation traps on overflow |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand or shift amount |
| imm22 | input | 22 | Immediate for set-high |
| result | output | 32 | Registered result |
| res_we | output | 1 | Result is to be written back |
| cc_we | output | 1 | Flags were updated this cycle |
| cc_flags | output | 4 | New flags {N,Z,V,C} |
| trap_req | output | 1 | Trap raised by a checked tagged operation |
| trap_code | output | 7 | Trap code, 0x0A with trap_req, else 0 |
| status_word | output | 32 | Stored flags at bits 23:20 |

## Verification
The risky overlap is a checked tagged operation that also carries an ordinary signed overflow or a carry, in the same cycle as a flag update that the next carry-consuming operation depends on. The bench issues tagged operations in both forms with tag bits, sign overflows and carries mixed, followed directly by add-with-carry and subtract-with-borrow operations. It judges each cycle against a reference model whose flags are kept separately, so a trap that leaks a flag update or a write shows up at once in `status_word` and in the next chained result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_OR    = 4'd1,
        OP_XOR   = 4'd2,
        OP_ANDN  = 4'd3,
        OP_ORN   = 4'd4,
        OP_XNOR  = 4'd5,
        OP_ADD   = 4'd6,
        OP_ADDC  = 4'd7,
        OP_SUB   = 4'd8,
        OP_SUBC  = 4'd9,
        OP_TADD  = 4'd10,
        OP_TSUB  = 4'd11,
        OP_SHL   = 4'd12,
        OP_SHRL  = 4'd13,
        OP_SHRA  = 4'd14,
        OP_SETHI = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    function automatic logic is_logic_op(alu_op_e o);
        return o <= OP_XNOR;
    endfunction

    function automatic logic is_arith_op(alu_op_e o);
        return (o >= OP_ADD) && (o <= OP_TSUB);
    endfunction

    function automatic logic is_tag_op(alu_op_e o);
        return (o == OP_TADD) || (o == OP_TSUB);
    endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = (op == OP_ANDN || op == OP_ORN || op == OP_XNOR) ? ~b : b;
        unique case (op)
            OP_AND, OP_ANDN: y = a & b_eff;
            OP_OR,  OP_ORN:  y = a | b_eff;
            default:         y = a ^ b_eff;
        endcase
    end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int TAG_W = 2
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           c_flag,
    output logic [W-1:0]   y,
    output logic           c_out,
    output logic           ovf,
    output logic           tag_bad
);
    localparam int MSB = W - 1;

    logic         do_sub;
    logic         ci;
    logic [W:0]   wide;

    always_comb begin
        do_sub  = (op == OP_SUB) || (op == OP_SUBC) || (op == OP_TSUB);
        ci      = ((op == OP_ADDC) || (op == OP_SUBC)) ? c_flag : 1'b0;
        if (do_sub)
            wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, ci};
        else
            wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        y     = wide[W-1:0];
        c_out = wide[W];
        if (do_sub)
            ovf = (a[MSB] != b[MSB]) && (y[MSB] != a[MSB]);
        else
            ovf = (a[MSB] == b[MSB]) && (y[MSB] != a[MSB]);
        tag_bad = (|a[TAG_W-1:0]) || (|b[TAG_W-1:0]);
    end
endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 22
) (
    input  alu_op_e               op,
    input  logic [W-1:0]          a,
    input  logic [$clog2(W)-1:0]  amt,
    input  logic [IMM_W-1:0]      imm,
    output logic [W-1:0]          y
);
    localparam int LOW_W = W - IMM_W;

    always_comb begin
        unique case (op)
            OP_SHL:  y = a << amt;
            OP_SHRL: y = a >> amt;
            OP_SHRA: y = W'($signed(a) >>> amt);
            default: y = {imm, {LOW_W{1'b0}}};
        endcase
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import alu_pkg::*;
#(
    parameter int          W         = 32,
    parameter int          IMM_W     = 22,
    parameter int          TRAP_W    = 7,
    parameter logic [6:0]  TAG_TRAP  = 7'h0A,
    parameter int          CC_LSB    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [3:0]        op,
    input  logic              set_cc,
    input  logic              trap_form,
    input  logic [W-1:0]      opa,
    input  logic [W-1:0]      opb,
    input  logic [IMM_W-1:0]  imm22,
    output logic [W-1:0]      result,
    output logic              res_we,
    output logic              cc_we,
    output logic [3:0]        cc_flags,
    output logic              trap_req,
    output logic [TRAP_W-1:0] trap_code,
    output logic [W-1:0]      status_word
);
    localparam int SH_W = $clog2(W);

    typedef struct packed {
        logic [W-1:0] res;
        logic         res_we;
        logic         cc_we;
        cc_t          cc;
        logic         trap;
        cc_t          icc;
    } state_t;

    state_t  st_d, st_q;
    alu_op_e op_e;

    logic [W-1:0] y_logic, y_arith, y_shift, y_sel;
    logic         a_cout, a_ovf, a_tag;
    logic         v_calc, c_calc, checked;
    cc_t          cc_calc;

    assign op_e = alu_op_e'(op);

    alu_logic_unit #(.W(W)) u_logic (
        .op(op_e), .a(opa), .b(opb), .y(y_logic)
    );

    alu_arith_unit #(.W(W), .TAG_W(2)) u_arith (
        .op(op_e), .a(opa), .b(opb), .c_flag(st_q.icc.c),
        .y(y_arith), .c_out(a_cout), .ovf(a_ovf), .tag_bad(a_tag)
    );

    alu_shift_unit #(.W(W), .IMM_W(IMM_W)) u_shift (
        .op(op_e), .a(opa), .amt(opb[SH_W-1:0]), .imm(imm22), .y(y_shift)
    );

    always_comb begin
        if (is_logic_op(op_e))      y_sel = y_logic;
        else if (is_arith_op(op_e)) y_sel = y_arith;
        else                        y_sel = y_shift;

        v_calc  = is_arith_op(op_e) ? (a_ovf | (is_tag_op(op_e) & a_tag)) : 1'b0;
        c_calc  = is_arith_op(op_e) ? a_cout : 1'b0;
        cc_calc = '{n: y_sel[W-1], z: (y_sel == '0), v: v_calc, c: c_calc};
        checked = is_tag_op(op_e) && trap_form;

        st_d        = st_q;
        st_d.res_we = 1'b0;
        st_d.cc_we  = 1'b0;
        st_d.trap   = 1'b0;
        if (in_valid) begin
            if (checked && v_calc) begin
                st_d.trap = 1'b1;
            end else begin
                st_d.res    = y_sel;
                st_d.res_we = 1'b1;
                if (set_cc || checked) begin
                    st_d.cc_we = 1'b1;
                    st_d.cc    = cc_calc;
                    st_d.icc   = cc_calc;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status_word = '0;
        status_word[CC_LSB +: 4] = st_q.icc;
    end

    assign result    = st_q.res;
    assign res_we    = st_q.res_we;
    assign cc_we     = st_q.cc_we;
    assign cc_flags  = st_q.cc;
    assign trap_req  = st_q.trap;
    assign trap_code = st_q.trap ? TAG_TRAP : '0;

    // R8: a trap carries its code and nothing is written
    p_trap_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_code == TAG_TRAP) && !res_we && !cc_we);

    // R11: stored flags move only with a flag update
    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_we |-> $stable(status_word));

    // R2: N and Z follow the written result
    p_nz_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cc_we |-> (cc_flags[3] == result[W-1]) && (cc_flags[2] == (result == '0)));

    // R3: logic operations that set flags clear V and C
    p_logic_vc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && set_cc && (op <= 4'd5)) |-> cc_we && !cc_flags[1] && !cc_flags[0]);

    // R7: tag bits in a non-checked tagged operation force V
    p_tag_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && set_cc && !trap_form && (op == 4'd10 || op == 4'd11)
              && ((opa[1:0] != 2'b00) || (opb[1:0] != 2'b00))) |-> cc_we && cc_flags[1]);

    // R12: no activity follows an idle cycle
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!in_valid) |-> !res_we && !cc_we && !trap_req);

endmodule

// File: tb/tb_int_exec_alu.sv
module tb_int_exec_alu;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic        set_cc = 1'b0;
    logic        trap_form = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [21:0] imm22 = '0;
    logic [31:0] result;
    logic        res_we;
    logic        cc_we;
    logic [3:0]  cc_flags;
    logic        trap_req;
    logic [6:0]  trap_code;
    logic [31:0] status_word;

    int n_checks = 0;
    int n_fail   = 0;
    logic [3:0] m_icc = '0;
    bit done = 0;

    int_exec_alu dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .set_cc(set_cc),
        .trap_form(trap_form), .opa(opa), .opb(opb), .imm22(imm22),
        .result(result), .res_we(res_we), .cc_we(cc_we), .cc_flags(cc_flags),
        .trap_req(trap_req), .trap_code(trap_code), .status_word(status_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_for(logic [3:0] o);
        if (o <= 4'd5)  return "R1/R3";
        if (o == 4'd6)  return "R4";
        if (o == 4'd7)  return "R6";
        if (o == 4'd8)  return "R5";
        if (o == 4'd9)  return "R6";
        if (o <= 4'd11) return "R7/R8";
        if (o <= 4'd14) return "R9";
        return "R10";
    endfunction

    task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                         input logic [21:0] im, input logic sc, input logic tf,
                         output logic [31:0] r, output logic we, output logic ccwe,
                         output logic [3:0] cc, output logic trp);
        logic [32:0] s;
        logic v, c, sub, tag;
        v = 1'b0; c = 1'b0; s = '0;
        sub = (o == 4'd8) || (o == 4'd9) || (o == 4'd11);
        tag = (o == 4'd10) || (o == 4'd11);
        case (o)
            4'd0: r = a & b;
            4'd1: r = a | b;
            4'd2: r = a ^ b;
            4'd3: r = a & ~b;
            4'd4: r = a | ~b;
            4'd5: r = ~(a ^ b);
            4'd12: r = a << b[4:0];
            4'd13: r = a >> b[4:0];
            4'd14: r = 32'($signed(a) >>> b[4:0]);
            4'd15: r = {im, 10'b0};
            default: begin
                logic ci;
                ci = (o == 4'd7 || o == 4'd9) ? m_icc[0] : 1'b0;
                if (sub) s = {1'b0, a} - {1'b0, b} - 33'(ci);
                else     s = {1'b0, a} + {1'b0, b} + 33'(ci);
                r = s[31:0];
                c = s[32];
                if (sub) v = (a[31] ^ b[31]) & (r[31] ^ a[31]);
                else     v = ~(a[31] ^ b[31]) & (r[31] ^ a[31]);
                if (tag && (a[1:0] != 0 || b[1:0] != 0)) v = 1'b1;
            end
        endcase
        cc = {r[31], r == 0, v, c};
        trp = tag && tf && v;
        we = !trp;
        ccwe = !trp && (sc || (tag && tf));
    endtask

    task automatic check(string req, logic [77:0] act, logic [77:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(logic [3:0] o, logic [31:0] a, logic [31:0] b, logic [21:0] im,
                         logic sc, logic tf, string extra);
        logic [31:0] er; logic ewe, eccwe, etrp; logic [3:0] ecc;
        logic [77:0] act, exp;
        model(o, a, b, im, sc, tf, er, ewe, eccwe, ecc, etrp);
        in_valid = 1'b1; op = o; opa = a; opb = b; imm22 = im; set_cc = sc; trap_form = tf;
        @(posedge clk);
        @(negedge clk);
        if (eccwe) m_icc = ecc;
        act = {res_we, cc_we, trap_req, trap_code, res_we ? result : 32'h0,
               cc_we ? cc_flags : 4'h0, status_word};
        exp = {ewe, eccwe, etrp, etrp ? 7'h0A : 7'h00, ewe ? er : 32'h0,
               eccwe ? ecc : 4'h0, 8'h00, m_icc, 20'h0};
        check({req_for(o), " R2 R11 ", extra}, act, exp);
        in_valid = 1'b0;
    endtask

    task automatic idle_check(string req);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(req, {res_we, cc_we, trap_req, trap_code, 32'h0, 4'h0, status_word},
              {3'b000, 7'h00, 32'h0, 4'h0, 8'h00, m_icc, 20'h0});
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_fail++;
                $display("FAIL watchdog R12 actual=hung expected=finished");
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5A17C0DE));
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset", {res_we, cc_we, trap_req, trap_code, status_word, 36'h0},
              {3'b000, 7'h00, 32'h0, 36'h0});
        rst_n = 1'b1;
        idle_check("R12 idle after reset");

        // R4 signed overflow and carry out
        do_op(4'd6, 32'h7FFF_FFFF, 32'h1, 0, 1, 0, "add ovf");
        do_op(4'd6, 32'hFFFF_FFFF, 32'h1, 0, 1, 0, "add carry zero");
        // R6: C is set now; plain add ignores it, add-with-carry uses it
        do_op(4'd6, 32'd10, 32'd3, 0, 0, 0, "plain add ignores C");
        do_op(4'd7, 32'd5, 32'd6, 0, 1, 0, "addc uses C");
        // R5 borrow and overflow
        do_op(4'd8, 32'h8000_0000, 32'h1, 0, 1, 0, "sub ovf");
        do_op(4'd8, 32'd1, 32'd2, 0, 1, 0, "sub borrow");
        do_op(4'd9, 32'd10, 32'd3, 0, 1, 0, "subc uses borrow");
        // R3: logic clears V and C after they were set
        do_op(4'd6, 32'h8000_0000, 32'h8000_0000, 0, 1, 0, "set V C");
        do_op(4'd3, 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 1, 0, "andn clears VC");
        do_op(4'd4, 32'h0, 32'hFFFF_FFFF, 0, 1, 0, "orn zero");
        do_op(4'd5, 32'h1234_5678, 32'h1234_5678, 0, 1, 0, "xnor all ones");
        // R11: no flag update when set_cc is low
        do_op(4'd8, 32'd0, 32'd1, 0, 0, 0, "no flag update");
        idle_check("R11 idle keeps flags");
        // R7 tagged overflow from tag bits, non-trapping
        do_op(4'd10, 32'd4, 32'd1, 0, 1, 0, "tadd tag V");
        do_op(4'd11, 32'd8, 32'd4, 0, 1, 0, "tsub clean");
        // R8 checked form: trap suppresses write and flags
        do_op(4'd6, 32'hFFFF_FFFF, 32'h1, 0, 1, 0, "prime C");
        do_op(4'd10, 32'd6, 32'd4, 0, 1, 1, "tadd trap");
        do_op(4'd11, 32'h8000_0000, 32'd4, 0, 0, 1, "tsub ordinary ovf trap");
        do_op(4'd10, 32'd4, 32'd8, 0, 0, 1, "tadd checked clean updates");
        do_op(4'd1, 32'd3, 32'd4, 0, 1, 1, "trap_form ignored on or");
        // R9 shift amount low 5 bits
        do_op(4'd12, 32'h0000_0003, 32'd37, 0, 1, 0, "sll 37");
        do_op(4'd14, 32'h8000_0000, 32'hFFFF_FFE4, 0, 1, 0, "sra 4");
        do_op(4'd13, 32'h8000_0000, 32'd31, 0, 1, 0, "srl 31");
        // R10 set-high
        do_op(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 22'h3F_FFFF, 1, 0, "sethi ones");
        do_op(4'd15, 32'h0, 32'h0, 22'h0, 1, 0, "sethi zero");

        // random mix with tag-heavy operands and chained carries
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] o; logic [31:0] a, b;
            o = 4'($urandom_range(0, 15));
            a = $urandom; b = $urandom;
            if ($urandom_range(0, 3) == 0) a[1:0] = 2'b00;
            if ($urandom_range(0, 3) == 0) b[1:0] = 2'b00;
            if ($urandom_range(0, 7) == 0) a = 32'h7FFF_FFFC;
            do_op(o, a, b, 22'($urandom), 1'($urandom), 1'($urandom), "random");
            if ($urandom_range(0, 15) == 0) idle_check("R12 random idle");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule